// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a narrow port A and two wide-side ports, B1 and B2, that share one clock. Going from A towards the B side, words are staged so that two narrow words taken on successive cycles come out side by side as one double-width word. B1 takes the earlier word and B2 takes the later one. Going from the B side towards A, each B port has its own capture register, and a select bit that is registered on the clock edge chooses which of the two drives A.

Each bidirectional port is split into an input bus, an output bus and a drive flag, so the block has no tri-state pins. An output bus always shows the register behind it. The drive flag tells the surrounding logic whether that port is actually driving. The two direction controls are active low and are registered, so a change of bus direction takes effect on a clock edge. There is no valid/ready handshake. Data moves only under the per-register load strobes, so there is no back-pressure and the strobes are the whole flow-control contract. Every load strobe is active low.

Top module: `bus_exchanger`

## Requirements
- R1: A data register whose active-low load strobe is low at a rising clock edge takes its input value at that edge.
- R2: A data register whose load strobe is high at a rising edge keeps its earlier value, whatever its data input does.
- R3: The A-to-B1 path has two register stages that advance together under `ld_a1_n`. A word on `a_in` reaches `b1_out` after the second edge with `ld_a1_n` low, not after the first.
- R4: The A-to-B2 path has one register stage under `ld_a2_n`. `b2_out` shows `a_in` from the last edge with `ld_a2_n` low.
- R5: If `ld_a1_n` is low on two consecutive edges and `ld_a2_n` is also low on the second of them, then after that second edge `b1_out` holds the first word and `b2_out` holds the second word.
- R6: The B1 capture register loads `b1_in` under `ld_b1_n`, and the B2 capture register loads `b2_in` under `ld_b2_n`. The two are independent of each other.
- R7: `pick_b1` is sampled on the clock edge. After an edge where it was 1, `a_out` shows the B1 capture register. After an edge where it was 0, `a_out` shows the B2 capture register.
- R8: `a_oe_n` and `b_oe_n` are active low and registered. After each edge, `a_drive` equals NOT the sampled `a_oe_n`, and `b_drive` equals NOT the sampled `b_oe_n`. All four combinations are valid: neither side drives, only B, only A, or both.
- R9: An edge with `rst_n` low clears every data register and the registered select, and sets `a_drive` and `b_drive` to 0.
- R10: The output buses always show their registers' contents, even when the matching drive flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | W | Narrow-port input word |
| ld_a1_n | input | 1 | Load strobe for both A-to-B1 stages, active low |
| ld_a2_n | input | 1 | Load strobe for the A-to-B2 register, active low |
| b1_in | input | W | B1 input word |
| b2_in | input | W | B2 input word |
| ld_b1_n | input | 1 | Load strobe for the B1 capture register, active low |
| ld_b2_n | input | 1 | Load strobe for the B2 capture register, active low |
| pick_b1 | input | 1 | Registered source select for A: 1 selects B1, 0 selects B2 |
| a_oe_n | input | 1 | Registered drive request for A, active low |
| b_oe_n | input | 1 | Registered drive request for B1 and B2, active low |
| a_out | output | W | Value presented on A |
| a_drive | output | 1 | A is driving |
| b1_out | output | W | Value presented on B1 |
| b2_out | output | W | Value presented on B2 |
| b_drive | output | 1 | B1 and B2 are driving |

## Verification
On every cycle, the assertions check the following:
- each data register loads when its strobe is low and holds when it is high;
- the select-driven choice of `a_out` follows the sampled `pick_b1`;
- the drive flags follow the sampled direction controls;
- the word-pairing rule holds whenever its strobe pattern occurs;
- reset clears the drive flags.

Only the bench scenarios can show the following:
- a word needs exactly two strobed edges to reach B1;
- stale B-side words survive long sequences of hold cycles;
- reset in the middle of a run wipes every register;
- all four drive combinations occur with the expected data present at each step.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef enum logic {
    PICK_B2 = 1'b0,
    PICK_B1 = 1'b1
  } pick_e;
endpackage

// File: rtl/bx_en_reg.sv
module bx_en_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (!ld_n)  q <= d;
  end

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> q == $past(d));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(q));
endmodule

// File: rtl/bx_a2b_path.sv
module bx_a2b_path #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         ld_a1_n,
  input  logic         ld_a2_n,
  output logic [W-1:0] b1_q,
  output logic [W-1:0] b2_q
);
  localparam int LAST = STAGES - 1;
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = a_in;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    bx_en_reg #(.W(W)) u_stage (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_a1_n),
      .d(chain[s]), .q(chain[s+1])
    );
  end

  assign b1_q = chain[LAST+1];

  bx_en_reg #(.W(W)) u_b2 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_a2_n), .d(a_in), .q(b2_q)
  );
endmodule

// File: rtl/bx_b2a_path.sv
module bx_b2a_path
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         ld_b1_n,
  input  logic         ld_b2_n,
  input  logic         pick_b1,
  output logic [W-1:0] cap1_q,
  output logic [W-1:0] cap2_q,
  output logic [W-1:0] a_q
);
  pick_e pick_q;

  bx_en_reg #(.W(W)) u_cap1 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_b1_n), .d(b1_in), .q(cap1_q)
  );
  bx_en_reg #(.W(W)) u_cap2 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_b2_n), .d(b2_in), .q(cap2_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pick_q <= PICK_B2;
    else        pick_q <= pick_e'(pick_b1);
  end

  always_comb begin
    a_q = (pick_q == PICK_B1) ? cap1_q : cap2_q;
  end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         ld_a1_n,
  input  logic         ld_a2_n,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         ld_b1_n,
  input  logic         ld_b2_n,
  input  logic         pick_b1,
  input  logic         a_oe_n,
  input  logic         b_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  output logic [W-1:0] b1_out,
  output logic [W-1:0] b2_out,
  output logic         b_drive
);
  logic [W-1:0] cap1_q, cap2_q;

  bx_a2b_path #(.W(W), .STAGES(STAGES)) u_a2b (
    .clk(clk), .rst_n(rst_n), .a_in(a_in),
    .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n),
    .b1_q(b1_out), .b2_q(b2_out)
  );

  bx_b2a_path #(.W(W)) u_b2a (
    .clk(clk), .rst_n(rst_n), .b1_in(b1_in), .b2_in(b2_in),
    .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n), .pick_b1(pick_b1),
    .cap1_q(cap1_q), .cap2_q(cap2_q), .a_q(a_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_drive <= 1'b0;
      b_drive <= 1'b0;
    end else begin
      a_drive <= ~a_oe_n;
      b_drive <= ~b_oe_n;
    end
  end

  p_sel_b1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pick_b1 |=> a_out == cap1_q);
  p_sel_b2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_b1 |=> a_out == cap2_q);
  p_a_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> a_drive == !$past(a_oe_n));
  p_b_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> b_drive == !$past(b_oe_n));
  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (!a_drive && !b_drive && b1_out == '0 && b2_out == '0));

  if (STAGES == 2) begin : g_pair_chk
    p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_a1_n ##1 (!ld_a1_n && !ld_a2_n) |=>
        (b1_out == $past(a_in, 2) && b2_out == $past(a_in)));
  end
endmodule

// File: tb/tb_bus_exchanger.sv
module tb_bus_exchanger;
  localparam int W = 12;

  typedef struct {
    string        tag;
    logic [W-1:0] a, b1, b2;
    logic         ad, bd;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic         ld_a1_n = 1'b1, ld_a2_n = 1'b1, ld_b1_n = 1'b1, ld_b2_n = 1'b1;
  logic         pick_b1 = 1'b0, a_oe_n = 1'b1, b_oe_n = 1'b1;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_drive, b_drive;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  // reference state taken from the requirements
  logic [W-1:0] m_s1 = '0, m_s2 = '0, m_r2 = '0, m_c1 = '0, m_c2 = '0;
  logic         m_pick = 1'b0, m_ad = 1'b0, m_bd = 1'b0;

  always #2 clk = ~clk;

  bus_exchanger #(.W(W), .STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n),
    .b1_in(b1_in), .b2_in(b2_in), .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n),
    .pick_b1(pick_b1), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
    .a_out(a_out), .a_drive(a_drive), .b1_out(b1_out), .b2_out(b2_out),
    .b_drive(b_drive)
  );

  task automatic step(input logic rs, input logic [W-1:0] a, input logic [W-1:0] x1,
                      input logic [W-1:0] x2, input logic l1, input logic l2,
                      input logic lb1, input logic lb2, input logic pk,
                      input logic oa, input logic ob, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = rs; a_in = a; b1_in = x1; b2_in = x2;
    ld_a1_n = l1; ld_a2_n = l2; ld_b1_n = lb1; ld_b2_n = lb2;
    pick_b1 = pk; a_oe_n = oa; b_oe_n = ob;
    if (!rs) begin
      m_s1 = '0; m_s2 = '0; m_r2 = '0; m_c1 = '0; m_c2 = '0;
      m_pick = 1'b0; m_ad = 1'b0; m_bd = 1'b0;
    end else begin
      if (!l1) begin m_s2 = m_s1; m_s1 = a; end
      if (!l2) m_r2 = a;
      if (!lb1) m_c1 = x1;
      if (!lb2) m_c2 = x2;
      m_pick = pk; m_ad = !oa; m_bd = !ob;
    end
    e.tag = tag; e.a = m_pick ? m_c1 : m_c2; e.b1 = m_s2; e.b2 = m_r2;
    e.ad = m_ad; e.bd = m_bd;
    q.push_back(e);
  endtask

  // monitor: compares one expected item after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0 && !done) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (a_out !== e.a || b1_out !== e.b1 || b2_out !== e.b2 ||
          a_drive !== e.ad || b_drive !== e.bd) begin
        fails++;
        $display("FAIL %s: got a=%h b1=%h b2=%h ad=%b bd=%b exp a=%h b1=%h b2=%h ad=%b bd=%b",
                 e.tag, a_out, b1_out, b2_out, a_drive, b_drive,
                 e.a, e.b1, e.b2, e.ad, e.bd);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    step(0, 12'hFFF, 12'hFFF, 12'hFFF, 0, 0, 0, 0, 1, 0, 0, "R9_reset");
    step(0, 12'h123, 12'h456, 12'h789, 0, 0, 0, 0, 0, 0, 0, "R9_reset_hold");
    // R3 first word enters stage 1 only; R10 outputs visible while undriven
    step(1, 12'hA01, 0, 0, 0, 1, 1, 1, 0, 1, 1, "R3_first_edge");
    // R5 pair: second word with both A strobes low
    step(1, 12'hA02, 0, 0, 0, 0, 1, 1, 0, 1, 0, "R5_pair");
    // R2 hold: strobes high, inputs change
    step(1, 12'h5A5, 12'h111, 12'h222, 1, 1, 1, 1, 0, 1, 0, "R2_hold");
    // R4 single stage on B2 only
    step(1, 12'hB0B, 0, 0, 1, 0, 1, 1, 0, 1, 0, "R4_b2_only");
    // R3 second strobed edge moves word to B1
    step(1, 12'hC0C, 0, 0, 0, 1, 1, 1, 0, 1, 0, "R3_advance");
    step(1, 12'hD0D, 0, 0, 0, 1, 1, 1, 0, 1, 0, "R3_advance2");
    // R6 B captures, independent
    step(1, 0, 12'h3C1, 12'h3C2, 1, 1, 0, 1, 1, 0, 1, "R6_cap1");
    step(1, 0, 12'h4C1, 12'h4C2, 1, 1, 1, 0, 1, 0, 1, "R6_cap2");
    // R7 select low and high
    step(1, 0, 12'h777, 12'h888, 1, 1, 1, 1, 0, 0, 1, "R7_pick_b2");
    step(1, 0, 12'h777, 12'h888, 1, 1, 1, 1, 1, 0, 1, "R7_pick_b1");
    // R8 all drive combinations
    step(1, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, "R8_none");
    step(1, 0, 0, 0, 1, 1, 1, 1, 1, 1, 0, "R8_b_only");
    step(1, 0, 0, 0, 1, 1, 1, 1, 0, 0, 1, "R8_a_only");
    step(1, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0, "R8_both");
    // R1 every register loads together
    step(1, 12'h9E1, 12'h9E2, 12'h9E3, 0, 0, 0, 0, 1, 0, 0, "R1_all_load");
    step(1, 12'h9F1, 12'h9F2, 12'h9F3, 0, 0, 0, 0, 0, 0, 0, "R1_all_load2");
    // R10 data visible with drives off
    step(1, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, "R10_undriven");
    // R9 mid-run reset
    step(0, 12'h111, 12'h222, 12'h333, 0, 0, 0, 0, 1, 0, 0, "R9_midrun");
    step(1, 12'h0AA, 0, 0, 0, 0, 1, 1, 0, 1, 1, "R9_after");
    // drain the queue
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule